// File: doc/BRIEF.md
# Self-Timed Nonvolatile Write Sequencer

This block is the clocked control logic of an embedded parallel nonvolatile memory macro. A host drives it much like a static RAM, using three active-low strobes: select, output enable and write. A separate active-low fill input asks for every word to be written at once, and an active-low halt input blocks writes and cancels a cycle that is already running. The storage is an array of registers whose word count and width are parameters. Tri-state pins are modelled as a data bus plus a drive-enable output.

A write begins when the select and write strobes are both low, output enable is high and halt is high. The block latches the address as soon as it sees both strobes low. It latches the data when the first of the two strobes rises. It then runs by itself through a timed clear phase and a timed program phase. During that time the ready flag is held low. The flag goes high again only when the cycle is complete. A fill cycle writes the latched word into every location and takes a fixed multiple of the byte-write time.

All strobes pass through a two-flop synchroniser before edge detection. The phase lengths are parameters given in clock cycles. The depth must be a power of two from 16 to 16K words. The width must be a multiple of 4 bits, from 4 to 128.

Top module: `nvm_write_seq`

## Requirements
- R1: dout_oe is 1 exactly when sel_n=0, look_n=0 and strobe_n=1. dout always shows the stored word at addr.
- R2: A write cycle starts after a fresh moment in which sel_n=0 and strobe_n=0 together, with look_n=1, halt_n=1 and fill_n=1. It starts once either strobe rises. ready then drops to 0.
- R3: The address is taken when both strobes are first seen low, so later changes to addr are ignored. The data is taken when the first strobe rises, so the last din value before release is written.
- R4: A byte write keeps ready at 0 for exactly CLR_CYC+PGM_CYC clock cycles. The clear phase always comes before the program phase.
- R5: A write with fill_n=0 while the strobes are low writes the latched word into every location. It keeps ready at 0 for exactly ALL_X*(CLR_CYC+PGM_CYC) cycles.
- R6: Reads while ready=0 return the previous contents. The array changes only in the last cycle of the program phase.
- R7: Strobe activity while ready=0 is ignored. This includes strobes that are held low across the release of ready: no second cycle starts and no word changes.
- R8: While halt_n=0 no write starts. Pulling halt_n low during a cycle sets ready to 1 on the next clock and leaves the array unchanged.
- R9: Pulling look_n low before the strobes are released cancels the pending write.
- R10: After rst_n, ready=1 and no write is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset of the sequencer (the array is not reset) |
| sel_n | input | 1 | Active-low select strobe |
| look_n | input | 1 | Active-low output enable |
| strobe_n | input | 1 | Active-low write strobe |
| fill_n | input | 1 | Active-low request to write every word |
| halt_n | input | 1 | Active-low write inhibit and cycle abort |
| addr | input | $clog2(WORDS) | Word address |
| din | input | WIDTH | Write data |
| dout | output | WIDTH | Read data |
| dout_oe | output | 1 | Drive enable for dout |
| ready | output | 1 | 1 when idle, 0 during an internal write cycle |

## Verification
A host read can fall in the same cycle as an internal write that is still running. The bench provokes this by waiting until ready drops and then driving a read of the target address. The returned word must match the old model contents, and the new word must appear only after ready rises. A second overlap is host strobe activity during busy, including strobes held low while ready is released. It is judged by checking that ready stays high afterwards and that the address the strobes pointed at still holds its old word.

// File: rtl/nvm_write_seq.sv
module nvm_write_seq #(
  parameter int WORDS   = 16,
  parameter int WIDTH   = 8,
  parameter int CLR_CYC = 4,
  parameter int PGM_CYC = 6,
  parameter int ALL_X   = 10
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       sel_n,
  input  logic                       look_n,
  input  logic                       strobe_n,
  input  logic                       fill_n,
  input  logic                       halt_n,
  input  logic [$clog2(WORDS)-1:0]   addr,
  input  logic [WIDTH-1:0]           din,
  output logic [WIDTH-1:0]           dout,
  output logic                       dout_oe,
  output logic                       ready
);
  localparam int AW       = $clog2(WORDS);
  localparam int BYTE_LEN = CLR_CYC + PGM_CYC;
  localparam int ALL_LEN  = ALL_X * BYTE_LEN;
  localparam int CW       = $clog2(ALL_LEN + 1);
  localparam logic [CW-1:0] CLR_B = CW'(CLR_CYC - 1);
  localparam logic [CW-1:0] PGM_B = CW'(PGM_CYC - 1);
  localparam logic [CW-1:0] CLR_A = CW'(ALL_X * CLR_CYC - 1);
  localparam logic [CW-1:0] PGM_A = CW'(ALL_X * PGM_CYC - 1);
  localparam logic [CW-1:0] END_B = CW'(BYTE_LEN - 1);
  localparam logic [CW-1:0] END_A = CW'(ALL_LEN - 1);

  typedef enum logic [1:0] {IDLE, CLEAR, PROG} phase_t;

  logic [WIDTH-1:0] mem [WORDS];
  logic [3:0]       m1, m2;
  logic             both_low_d, armed, all_lat;
  logic [AW-1:0]    a_lat;
  logic [WIDTH-1:0] d_lat;
  phase_t           ph;
  logic [CW-1:0]    cnt, bcnt;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      m1 <= 4'hF;
      m2 <= 4'hF;
    end else begin
      m1 <= {sel_n, strobe_n, look_n, fill_n};
      m2 <= m1;
    end

  wire sel_q    = m2[3];
  wire wr_q     = m2[2];
  wire oe_q     = m2[1];
  wire fill_q   = m2[0];
  wire both_low = !sel_q && !wr_q;
  wire idle     = (ph == IDLE);
  wire arm_now  = idle && halt_n && oe_q && both_low && !both_low_d && !armed;
  wire fire     = armed && halt_n && oe_q && !both_low;
  wire done     = (ph == PROG) && (cnt == '0) && halt_n;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      both_low_d <= 1'b0;
      armed      <= 1'b0;
      all_lat    <= 1'b0;
      a_lat      <= '0;
      d_lat      <= '0;
      ph         <= IDLE;
      cnt        <= '0;
    end else begin
      both_low_d <= both_low;
      if (!halt_n) begin
        armed <= 1'b0;
        ph    <= IDLE;
        cnt   <= '0;
      end else begin
        case (ph)
          IDLE:
            if (arm_now) begin
              armed   <= 1'b1;
              a_lat   <= addr;
              all_lat <= !fill_q;
            end else if (armed && !oe_q) begin
              armed <= 1'b0;
            end else if (fire) begin
              armed <= 1'b0;
              d_lat <= din;
              ph    <= CLEAR;
              cnt   <= all_lat ? CLR_A : CLR_B;
            end
          CLEAR:
            if (cnt == '0) begin
              ph  <= PROG;
              cnt <= all_lat ? PGM_A : PGM_B;
            end else begin
              cnt <= cnt - 1'b1;
            end
          PROG:
            if (cnt == '0) ph <= IDLE;
            else           cnt <= cnt - 1'b1;
          default: ph <= IDLE;
        endcase
      end
    end

  always_ff @(posedge clk)
    if (done) begin
      if (all_lat) for (int i = 0; i < WORDS; i++) mem[i] <= d_lat;
      else         mem[a_lat] <= d_lat;
    end

  assign dout    = mem[addr];
  assign dout_oe = !sel_n && !look_n && strobe_n;
  assign ready   = idle;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)    bcnt <= '0;
    else if (idle) bcnt <= '0;
    else           bcnt <= bcnt + 1'b1;

  assert_start_cond_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ready) |-> $past(oe_q && halt_n && (sel_q || wr_q)));

  assert_clear_first_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == PROG && $past(ph) != PROG) |-> $past(ph) == CLEAR);

  assert_cycle_len_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> bcnt == (all_lat ? END_A : END_B));

  assert_hold_contents_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!idle && !done) |=> $stable(mem[a_lat]));

  assert_abort_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !halt_n |=> ready);
endmodule

// File: tb/tb_nvm_write_seq.sv
module tb_nvm_write_seq;
  localparam int WORDS = 16, WIDTH = 8, CLR = 4, PGM = 6, AX = 10;

  logic clk = 0, rst_n = 0;
  logic sel_n = 1, look_n = 1, strobe_n = 1, fill_n = 1, halt_n = 1;
  logic [3:0] addr = '0;
  logic [WIDTH-1:0] din = '0, dout;
  logic dout_oe, ready;

  nvm_write_seq #(.WORDS(WORDS), .WIDTH(WIDTH), .CLR_CYC(CLR), .PGM_CYC(PGM), .ALL_X(AX)) dut (
    .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .look_n(look_n), .strobe_n(strobe_n),
    .fill_n(fill_n), .halt_n(halt_n), .addr(addr), .din(din), .dout(dout),
    .dout_oe(dout_oe), .ready(ready));

  always #10 clk = ~clk;

  int vecs = 0, bad = 0, n;
  bit finished = 0, seen_busy;
  logic [WIDTH-1:0] model [WORDS];

  function automatic int exp_len(input bit all);
    return all ? AX * (CLR + PGM) : CLR + PGM;
  endfunction

  task automatic tick(input int k);
    repeat (k) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vecs++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic start_write(input int a, input int d, input bit all, input bit ce_ctl);
    addr = 4'(a); din = 8'(d); fill_n = !all; look_n = 1;
    if (ce_ctl) begin strobe_n = 0; tick(1); sel_n = 0; end
    else        begin sel_n = 0;    tick(1); strobe_n = 0; end
    tick(4);
    sel_n = 1; strobe_n = 1;
  endtask

  task automatic wait_busy(output int cnt);
    int g = 0;
    while (ready && g < 40) begin tick(1); g++; end
    cnt = 0;
    while (!ready && cnt < 3000) begin cnt++; tick(1); end
    fill_n = 1;
  endtask

  task automatic rd_chk(input int a, input string req);
    addr = 4'(a); strobe_n = 1; sel_n = 0; look_n = 0;
    tick(1);
    chk(dout == model[a] && dout_oe, req, dout, model[a]);
    sel_n = 1; look_n = 1;
  endtask

  task automatic quiet(input int k, output bit busy);
    busy = 0;
    repeat (k) begin tick(1); if (!ready) busy = 1; end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      bad++; vecs++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed));
    tick(3); rst_n = 1; tick(2);
    chk(ready == 1, "R10 ready after reset", ready, 1);
    chk(dout_oe == 0, "R10 no drive after reset", dout_oe, 0);

    start_write(0, 8'h5A, 1, 1); wait_busy(n);
    chk(n == exp_len(1), "R5 fill busy length", n, exp_len(1));
    for (int i = 0; i < WORDS; i++) model[i] = 8'h5A;
    for (int i = 0; i < WORDS; i++) rd_chk(i, "R5 fill contents");

    start_write(3, 8'h3C, 0, 0); wait_busy(n);
    chk(n == exp_len(0), "R4 byte busy length", n, exp_len(0));
    model[3] = 8'h3C;
    rd_chk(3, "R2 byte write data"); rd_chk(4, "R2 neighbour untouched");

    // R3: address latched early, data latched at release
    addr = 7; din = 8'h10; fill_n = 1; sel_n = 0; strobe_n = 0;
    tick(4); addr = 9; din = 8'h81; tick(2);
    sel_n = 1; strobe_n = 1; wait_busy(n);
    model[7] = 8'h81;
    rd_chk(7, "R3 latched address gets final data"); rd_chk(9, "R3 later address ignored");

    // R6: read of the target while the cycle runs
    start_write(2, 8'hC3, 0, 0);
    while (ready) tick(1);
    addr = 2; sel_n = 0; look_n = 0; tick(1);
    chk(dout == 8'h5A, "R6 read during busy returns old word", dout, 8'h5A);
    chk(dout_oe == 1, "R1 drive during busy read", dout_oe, 1);
    sel_n = 1; look_n = 1;
    wait_busy(n); model[2] = 8'hC3;
    rd_chk(2, "R6 new word after release");

    // R7: strobes during busy, held across release
    start_write(5, 8'h11, 0, 1);
    while (ready) tick(1);
    addr = 6; din = 8'h22; sel_n = 0; strobe_n = 0; tick(2);
    strobe_n = 1; tick(2); strobe_n = 0;
    while (!ready) tick(1);
    tick(5); sel_n = 1; strobe_n = 1;
    quiet(12, seen_busy);
    chk(!seen_busy, "R7 no cycle from busy strobes", seen_busy, 0);
    model[5] = 8'h11;
    rd_chk(6, "R7 busy strobe target unchanged"); rd_chk(5, "R7 first write intact");

    // R8: abort mid cycle
    start_write(8, 8'h77, 0, 0);
    while (ready) tick(1);
    tick(3); halt_n = 0; tick(1);
    chk(ready == 1, "R8 abort releases ready", ready, 1);
    halt_n = 1; tick(2);
    rd_chk(8, "R8 aborted word unchanged");

    // R8: inhibit, plus R1 drive combinations under inhibit
    halt_n = 0;
    for (int k = 0; k < 8; k++) begin
      {sel_n, look_n, strobe_n} = 3'(k); tick(1);
      chk(dout_oe == (k == 1), "R1 drive enable decode", dout_oe, k == 1);
    end
    sel_n = 1; look_n = 1; strobe_n = 1;
    start_write(9, 8'hEE, 0, 0); quiet(12, seen_busy);
    chk(!seen_busy, "R8 inhibit blocks start", seen_busy, 0);
    halt_n = 1; tick(2);
    rd_chk(9, "R8 inhibited word unchanged");

    // R9: output enable low before release cancels
    addr = 10; din = 8'h99; sel_n = 0; strobe_n = 0; tick(4);
    look_n = 0; tick(3);
    chk(dout_oe == 0, "R1 no drive with write strobe low", dout_oe, 0);
    sel_n = 1; strobe_n = 1; tick(1); look_n = 1;
    quiet(12, seen_busy);
    chk(!seen_busy, "R9 cancelled write", seen_busy, 0);
    rd_chk(10, "R9 word unchanged");

    // random mix
    for (int t = 0; t < 40; t++) begin
      int a = int'($urandom_range(WORDS - 1));
      int d = int'($urandom_range(255));
      bit all = ($urandom_range(7) == 0);
      bit cec = $urandom_range(1) == 1;
      start_write(a, d, all, cec); wait_busy(n);
      chk(n == exp_len(all), all ? "R5 random fill length" : "R4 random byte length", n, exp_len(all));
      if (all) for (int i = 0; i < WORDS; i++) model[i] = 8'(d);
      else model[a] = 8'(d);
      rd_chk(int'($urandom_range(WORDS - 1)), "R2 random read back");
      rd_chk(a, "R3 random target read");
    end

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end
endmodule